// File: doc/BRIEF.md
# Paravirtual Device Common Configuration Register Block

This block holds the common configuration window that a driver uses to bring up a paravirtual PCI device. A simple memory-mapped request carries a byte offset, an access-size code, a write flag and write data. The block answers every request with a registered response one cycle later. The decode depends on both the offset and the access size, so one offset can mean different things at different widths.

The device-wide state is a set of paged feature windows, a driver status byte, a configuration vector and a queue selector. The per-queue state sits in a bank of registers, one set per queue. Each set holds a ring length, an interrupt vector, an enable bit and three 64-bit ring base addresses. The bank is reached indirectly through the queue selector. The device offers its 64 feature bits through two 32-bit pages. When the driver acknowledges a page, the block emits a one-cycle strobe that carries the acknowledged bits already shifted into their 64-bit position.

A small state machine tracks the response slot. In `ST_IDLE` no response is pending. In `ST_RESP` the response of the previous cycle's request is on the outputs. Any request moves the machine to `ST_RESP`, whether it starts from `ST_IDLE` or from `ST_RESP`. A cycle without a request returns the machine to `ST_IDLE`.

Top module: `pvcfg_regs`

## Requirements
- R1: After reset every stored register is 0: feature selects, status, configuration vector, queue selector, and all per-queue fields and ring addresses. `rsp_valid`, `ack_valid` and `invalid_access` are also low.
- R2: Every request cycle produces `rsp_valid` in the following cycle. Read data is LSB-justified with the unused upper bits zero, and write responses carry zero data. The size code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R3: The 1-byte register at 0x14 is driver status and is fully read/write. A 1-byte read at 0x15 returns the `cfg_generation` input, and a write there changes nothing.
- R4: The 4-byte registers at 0x00 (device feature page select) and 0x08 (driver feature page select) are read/write across all 32 bits.
- R5: A 4-byte read at 0x04 returns device feature bits [31:0] when the device page select is 0. It returns bits [63:32] when the select is 1, and 0 for any larger select.
- R6: A 4-byte write at 0x0C with a driver page select below 2 pulses `ack_valid` for one cycle. `ack_mask` then carries the value in bits [31:0] for page 0 or in bits [63:32] for page 1. When the select is 2 or more, there is no pulse and `invalid_access` pulses instead.
- R7: The 2-byte registers at 0x10 (configuration vector) and 0x16 (queue selector) are read/write. A 2-byte read at 0x12 returns `queue_count`, and a 2-byte read at 0x1E returns the queue selector.
- R8: 2-byte accesses at 0x18 (ring length), 0x1A (queue vector) and 0x1C (enable) act on the selected queue. The enable field is set only by a written value of exactly 1, and any other value clears it. Enable reads back as 1 or 0.
- R9: When the selector is not below both `NUM_Q` and `queue_count`, per-queue reads return 0 and per-queue writes change no queue.
- R10: Ring bases sit at 0x20 (descriptor), 0x28 (available) and 0x30 (used). A 4-byte write at the base replaces bits [31:0], and a 4-byte write at base+4 replaces bits [63:32]. An 8-byte write at the base replaces all 64 bits.
- R11: Every 8-byte read returns 0. An 8-byte read at a ring base is not flagged as invalid.
- R12: A size/offset pair that is not listed above changes nothing, reads 0, and pulses `invalid_access` together with its response.
- R13: Writes to the read-only 0x04, 0x12 and 0x1E are dropped without raising `invalid_access`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 6 | Byte offset in the window |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Write value, LSB-justified |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read value, LSB-justified |
| invalid_access | output | 1 | Pulse: the previous request was not accepted |
| dev_features | input | 64 | Feature bits offered by the device |
| cfg_generation | input | 8 | Configuration generation counter |
| queue_count | input | 16 | Number of queues the device exposes |
| drv_status | output | 8 | Driver status register |
| cfg_vector | output | 16 | Configuration interrupt vector |
| ack_valid | output | 1 | Feature acknowledge strobe |
| ack_mask | output | 64 | Acknowledged feature bits in position |
| q_size | output | 16*NUM_Q | Ring lengths, queue i at [16i+15:16i] |
| q_vector | output | 16*NUM_Q | Queue interrupt vectors |
| q_enable | output | NUM_Q | Queue enable bits |
| q_desc | output | 64*NUM_Q | Descriptor ring bases |
| q_avail | output | 64*NUM_Q | Available ring bases |
| q_used | output | 64*NUM_Q | Used ring bases |

## Verification
The same offsets are tried at several access sizes. This separates the size-qualified decode from a decode on offset alone: for example, a 2-byte access at the 1-byte status offset must be rejected. Both feature pages and an out-of-range page are used for the feature windows and the acknowledge path, which shows that page selection really shifts the data. Per-queue writes are aimed at a selector inside range, a selector equal to `queue_count`, and a selector beyond `NUM_Q`. The ring bases are written as a low half, as a high half and as one 64-bit word, to show that each form replaces only its own bits.

// File: rtl/pvcfg_pkg.sv
package pvcfg_pkg;

    localparam int OFF_W  = 6;
    localparam int DATA_W = 64;
    localparam int HALF_W = 32;
    localparam int VEC_W  = 16;
    localparam int STAT_W = 8;
    localparam int NPAGES = 2;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    typedef enum logic [4:0] {
        RID_NONE,
        RID_DEVFSEL,
        RID_DEVFEAT,
        RID_DRVFSEL,
        RID_DRVFEAT,
        RID_CFGVEC,
        RID_NUMQ,
        RID_STATUS,
        RID_GEN,
        RID_QSEL,
        RID_QSIZE,
        RID_QVEC,
        RID_QEN,
        RID_QNOTIFY,
        RID_RING_LO,
        RID_RING_HI,
        RID_RING_64
    } reg_id_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    // Next value of a 64-bit ring base for a given ring access kind.
    function automatic logic [DATA_W-1:0] ring_next(
        input logic [DATA_W-1:0] cur,
        input reg_id_e           rid,
        input logic [DATA_W-1:0] w
    );
        logic [DATA_W-1:0] r;
        r = cur;
        case (rid)
            RID_RING_LO: r = {cur[DATA_W-1:HALF_W], w[HALF_W-1:0]};
            RID_RING_HI: r = {w[HALF_W-1:0], cur[HALF_W-1:0]};
            RID_RING_64: r = w;
            default:     r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pvcfg_decode.sv
module pvcfg_decode
    import pvcfg_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  acc_size_e        size,
    output reg_id_e          rid,
    output logic [1:0]       ring
);

    // Ring bases at 0x20/0x28/0x30 give ring index 0/1/2 from offset bits [4:3].
    assign ring = offset[4:3];

    always_comb begin
        rid = RID_NONE;
        unique case (size)
            SZ_B1: begin
                case (offset)
                    6'h14:   rid = RID_STATUS;
                    6'h15:   rid = RID_GEN;
                    default: rid = RID_NONE;
                endcase
            end
            SZ_B2: begin
                case (offset)
                    6'h10:   rid = RID_CFGVEC;
                    6'h12:   rid = RID_NUMQ;
                    6'h16:   rid = RID_QSEL;
                    6'h18:   rid = RID_QSIZE;
                    6'h1A:   rid = RID_QVEC;
                    6'h1C:   rid = RID_QEN;
                    6'h1E:   rid = RID_QNOTIFY;
                    default: rid = RID_NONE;
                endcase
            end
            SZ_B4: begin
                case (offset)
                    6'h00:               rid = RID_DEVFSEL;
                    6'h04:               rid = RID_DEVFEAT;
                    6'h08:               rid = RID_DRVFSEL;
                    6'h0C:               rid = RID_DRVFEAT;
                    6'h20, 6'h28, 6'h30: rid = RID_RING_LO;
                    6'h24, 6'h2C, 6'h34: rid = RID_RING_HI;
                    default:             rid = RID_NONE;
                endcase
            end
            SZ_B8: begin
                case (offset)
                    6'h20, 6'h28, 6'h30: rid = RID_RING_64;
                    default:             rid = RID_NONE;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/pvcfg_queue_bank.sv
module pvcfg_queue_bank
    import pvcfg_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int QIDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    sel_ok,
    input  logic [QIDX_W-1:0]       idx,
    input  reg_id_e                 rid,
    input  logic [1:0]              ring,
    input  logic [DATA_W-1:0]       wdata,
    output logic [VEC_W-1:0]        rd_size,
    output logic [VEC_W-1:0]        rd_vec,
    output logic                    rd_en,
    output logic [NUM_Q*VEC_W-1:0]  q_size,
    output logic [NUM_Q*VEC_W-1:0]  q_vector,
    output logic [NUM_Q-1:0]        q_enable,
    output logic [NUM_Q*DATA_W-1:0] q_desc,
    output logic [NUM_Q*DATA_W-1:0] q_avail,
    output logic [NUM_Q*DATA_W-1:0] q_used
);

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_queue
        logic              hit;
        logic [VEC_W-1:0]  size_r;
        logic [VEC_W-1:0]  vec_r;
        logic              en_r;
        logic [DATA_W-1:0] desc_r;
        logic [DATA_W-1:0] avail_r;
        logic [DATA_W-1:0] used_r;

        assign hit = wr_en && sel_ok && (idx == QIDX_W'(gi));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                size_r  <= '0;
                vec_r   <= '0;
                en_r    <= 1'b0;
                desc_r  <= '0;
                avail_r <= '0;
                used_r  <= '0;
            end else if (hit) begin
                case (rid)
                    RID_QSIZE: size_r <= wdata[VEC_W-1:0];
                    RID_QVEC:  vec_r  <= wdata[VEC_W-1:0];
                    RID_QEN:   en_r   <= (wdata[VEC_W-1:0] == VEC_W'(1));
                    RID_RING_LO, RID_RING_HI, RID_RING_64: begin
                        case (ring)
                            2'd0:    desc_r  <= ring_next(desc_r, rid, wdata);
                            2'd1:    avail_r <= ring_next(avail_r, rid, wdata);
                            2'd2:    used_r  <= ring_next(used_r, rid, wdata);
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end

        assign q_size[gi*VEC_W +: VEC_W]     = size_r;
        assign q_vector[gi*VEC_W +: VEC_W]   = vec_r;
        assign q_enable[gi]                  = en_r;
        assign q_desc[gi*DATA_W +: DATA_W]   = desc_r;
        assign q_avail[gi*DATA_W +: DATA_W]  = avail_r;
        assign q_used[gi*DATA_W +: DATA_W]   = used_r;
    end

    always_comb begin
        rd_size = '0;
        rd_vec  = '0;
        rd_en   = 1'b0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (sel_ok && (idx == QIDX_W'(i))) begin
                rd_size = q_size[i*VEC_W +: VEC_W];
                rd_vec  = q_vector[i*VEC_W +: VEC_W];
                rd_en   = q_enable[i];
            end
        end
    end

endmodule

// File: rtl/pvcfg_regs.sv
module pvcfg_regs
    import pvcfg_pkg::*;
#(
    parameter int NUM_Q = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [OFF_W-1:0]        req_offset,
    input  logic [1:0]              req_size,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    invalid_access,
    input  logic [DATA_W-1:0]       dev_features,
    input  logic [STAT_W-1:0]       cfg_generation,
    input  logic [VEC_W-1:0]        queue_count,
    output logic [STAT_W-1:0]       drv_status,
    output logic [VEC_W-1:0]        cfg_vector,
    output logic                    ack_valid,
    output logic [DATA_W-1:0]       ack_mask,
    output logic [NUM_Q*VEC_W-1:0]  q_size,
    output logic [NUM_Q*VEC_W-1:0]  q_vector,
    output logic [NUM_Q-1:0]        q_enable,
    output logic [NUM_Q*DATA_W-1:0] q_desc,
    output logic [NUM_Q*DATA_W-1:0] q_avail,
    output logic [NUM_Q*DATA_W-1:0] q_used
);

    localparam int QIDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

    rsp_state_e        state_q, state_d;
    reg_id_e           rid;
    logic [1:0]        ring;
    logic [HALF_W-1:0] dev_fsel, drv_fsel;
    logic [VEC_W-1:0]  qsel;
    logic [HALF_W-1:0] dev_page;
    logic              sel_ok, ack_ok, wr_go, ack_go, bad;
    logic [DATA_W-1:0] rd_c;
    logic [VEC_W-1:0]  bank_size, bank_vec;
    logic              bank_en;

    pvcfg_decode u_decode (
        .offset (req_offset),
        .size   (acc_size_e'(req_size)),
        .rid    (rid),
        .ring   (ring)
    );

    assign sel_ok = (qsel < VEC_W'(NUM_Q)) && (qsel < queue_count);
    assign ack_ok = drv_fsel < HALF_W'(NPAGES);
    assign wr_go  = req_valid && req_write;
    assign ack_go = wr_go && (rid == RID_DRVFEAT) && ack_ok;
    assign bad    = (rid == RID_NONE) || (req_write && (rid == RID_DRVFEAT) && !ack_ok);

    pvcfg_queue_bank #(
        .NUM_Q  (NUM_Q),
        .QIDX_W (QIDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_go),
        .sel_ok   (sel_ok),
        .idx      (qsel[QIDX_W-1:0]),
        .rid      (rid),
        .ring     (ring),
        .wdata    (req_wdata),
        .rd_size  (bank_size),
        .rd_vec   (bank_vec),
        .rd_en    (bank_en),
        .q_size   (q_size),
        .q_vector (q_vector),
        .q_enable (q_enable),
        .q_desc   (q_desc),
        .q_avail  (q_avail),
        .q_used   (q_used)
    );

    // Paged view of the device feature vector.
    always_comb begin
        if (dev_fsel == HALF_W'(0)) begin
            dev_page = dev_features[HALF_W-1:0];
        end else if (dev_fsel == HALF_W'(1)) begin
            dev_page = dev_features[DATA_W-1:HALF_W];
        end else begin
            dev_page = '0;
        end
    end

    // Read multiplexer; write-only and 8-byte accesses read as zero.
    always_comb begin
        rd_c = '0;
        unique case (rid)
            RID_DEVFSEL:              rd_c = DATA_W'(dev_fsel);
            RID_DEVFEAT:              rd_c = DATA_W'(dev_page);
            RID_DRVFSEL:              rd_c = DATA_W'(drv_fsel);
            RID_CFGVEC:               rd_c = DATA_W'(cfg_vector);
            RID_NUMQ:                 rd_c = DATA_W'(queue_count);
            RID_STATUS:               rd_c = DATA_W'(drv_status);
            RID_GEN:                  rd_c = DATA_W'(cfg_generation);
            RID_QSEL, RID_QNOTIFY:    rd_c = DATA_W'(qsel);
            RID_QSIZE:                rd_c = DATA_W'(bank_size);
            RID_QVEC:                 rd_c = DATA_W'(bank_vec);
            RID_QEN:                  rd_c = DATA_W'(bank_en);
            default:                  rd_c = '0;
        endcase
    end

    // Device-wide registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_fsel   <= '0;
            drv_fsel   <= '0;
            cfg_vector <= '0;
            drv_status <= '0;
            qsel       <= '0;
        end else if (wr_go) begin
            case (rid)
                RID_DEVFSEL: dev_fsel   <= req_wdata[HALF_W-1:0];
                RID_DRVFSEL: drv_fsel   <= req_wdata[HALF_W-1:0];
                RID_CFGVEC:  cfg_vector <= req_wdata[VEC_W-1:0];
                RID_STATUS:  drv_status <= req_wdata[STAT_W-1:0];
                RID_QSEL:    qsel       <= req_wdata[VEC_W-1:0];
                default: ;
            endcase
        end
    end

    // Response slot state machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    // Registered outputs of the response slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata      <= '0;
            invalid_access <= 1'b0;
            ack_valid      <= 1'b0;
            ack_mask       <= '0;
        end else begin
            rsp_rdata      <= (req_valid && !req_write) ? rd_c : '0;
            invalid_access <= req_valid && bad;
            ack_valid      <= ack_go;
            if (ack_go) begin
                ack_mask <= drv_fsel[0] ? {req_wdata[HALF_W-1:0], {HALF_W{1'b0}}}
                                        : {{HALF_W{1'b0}}, req_wdata[HALF_W-1:0]};
            end else begin
                ack_mask <= '0;
            end
        end
    end

endmodule

// File: rtl/pvcfg_checker.sv
module pvcfg_checker
    import pvcfg_pkg::*;
#(
    parameter int NUM_Q = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [OFF_W-1:0]   req_offset,
    input logic [1:0]         req_size,
    input logic               rsp_valid,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic               invalid_access,
    input logic               ack_valid,
    input logic [DATA_W-1:0]  ack_mask,
    input logic [NUM_Q-1:0]   q_enable
);

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_ack_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(req_valid && req_write && req_offset == 6'h0C && req_size == 2'd2));

    assert_ack_one_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_mask[63:32] == '0 || ack_mask[31:0] == '0));

    assert_qword_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd3) |=> (rsp_rdata == '0));

    assert_enable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(q_enable));

    assert_invalid_in_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_access |-> rsp_valid);

endmodule

bind pvcfg_regs pvcfg_checker #(.NUM_Q(NUM_Q)) u_pvcfg_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_offset     (req_offset),
    .req_size       (req_size),
    .rsp_valid      (rsp_valid),
    .rsp_rdata      (rsp_rdata),
    .invalid_access (invalid_access),
    .ack_valid      (ack_valid),
    .ack_mask       (ack_mask),
    .q_enable       (q_enable)
);

// File: tb/pvcfg_regs_bench.sv
module pvcfg_regs_bench;

    localparam int NQ = 4;
    localparam logic [63:0] FEAT = 64'h1234_5678_9ABC_DEF0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [5:0]        req_offset = '0;
    logic [1:0]        req_size = '0;
    logic [63:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [63:0]       rsp_rdata;
    logic              invalid_access;
    logic [63:0]       dev_features = FEAT;
    logic [7:0]        cfg_generation = 8'h5A;
    logic [15:0]       queue_count = 16'd3;
    logic [7:0]        drv_status;
    logic [15:0]       cfg_vector;
    logic              ack_valid;
    logic [63:0]       ack_mask;
    logic [NQ*16-1:0]  q_size, q_vector;
    logic [NQ-1:0]     q_enable;
    logic [NQ*64-1:0]  q_desc, q_avail, q_used;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [63:0] rd;
        logic        inv;
        logic        ack;
        logic [63:0] mask;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    pvcfg_regs #(.NUM_Q(NQ)) u_pvcfg_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .invalid_access(invalid_access),
        .dev_features(dev_features), .cfg_generation(cfg_generation),
        .queue_count(queue_count), .drv_status(drv_status), .cfg_vector(cfg_vector),
        .ack_valid(ack_valid), .ack_mask(ack_mask), .q_size(q_size), .q_vector(q_vector),
        .q_enable(q_enable), .q_desc(q_desc), .q_avail(q_avail), .q_used(q_used)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Driver: one request per call, expected response pushed to the scoreboard.
    task automatic access(input bit w, input bit [1:0] sz, input bit [5:0] off,
                          input logic [63:0] wd, input logic [63:0] exp_rd,
                          input bit exp_inv, input bit exp_ack,
                          input logic [63:0] exp_mask, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = w;
        req_size   = sz;
        req_offset = off;
        req_wdata  = wd;
        e.rd = exp_rd; e.inv = exp_inv; e.ack = exp_ack; e.mask = exp_mask;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic wr(input bit [1:0] sz, input bit [5:0] off, input logic [63:0] wd,
                      input string tag);
        access(1'b1, sz, off, wd, 64'd0, 1'b0, 1'b0, 64'd0, tag);
    endtask

    task automatic rd(input bit [1:0] sz, input bit [5:0] off, input logic [63:0] exp,
                      input string tag);
        access(1'b0, sz, off, 64'd0, exp, 1'b0, 1'b0, 64'd0, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever a response appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " rdata"}, rsp_rdata, e.rd);
                check({t, " invalid"}, 64'(invalid_access), 64'(e.inv));
                check({t, " ack"}, 64'(ack_valid), 64'(e.ack));
                if (e.ack) check({t, " mask"}, ack_mask, e.mask);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 status", 64'(drv_status), 64'd0);
        check("R1 cfg vector", 64'(cfg_vector), 64'd0);
        check("R1 enables", 64'(q_enable), 64'd0);
        check("R1 desc", q_desc[63:0], 64'd0);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 flags", 64'({ack_valid, invalid_access}), 64'd0);
        rd(2'd2, 6'h00, 64'd0, "R1 dev fsel");
        rd(2'd2, 6'h08, 64'd0, "R1 drv fsel");
        rd(2'd1, 6'h16, 64'd0, "R1 qsel");

        // R3 status and generation
        wr(2'd0, 6'h14, 64'hFFFF_FFFF_FFFF_FF55, "R3 status wr");
        rd(2'd0, 6'h14, 64'h55, "R3 status rd");
        wr(2'd0, 6'h15, 64'hAA, "R3 gen wr");
        rd(2'd0, 6'h15, 64'h5A, "R3 gen rd");

        // R5 / R4 feature pages and selects
        rd(2'd2, 6'h04, 64'h9ABC_DEF0, "R5 page0");
        wr(2'd2, 6'h00, 64'd1, "R4 dev fsel wr");
        rd(2'd2, 6'h04, 64'h1234_5678, "R5 page1");
        wr(2'd2, 6'h00, 64'd2, "R4 dev fsel wr");
        rd(2'd2, 6'h04, 64'd0, "R5 page2");
        rd(2'd2, 6'h00, 64'd2, "R4 dev fsel rd");
        wr(2'd2, 6'h08, 64'h0403_0201, "R4 drv fsel wr");
        rd(2'd2, 6'h08, 64'h0403_0201, "R4 drv fsel rd");

        // R6 acknowledge pages
        wr(2'd2, 6'h08, 64'd1, "R6 sel1");
        access(1'b1, 2'd2, 6'h0C, 64'hCAFE_F00D, 64'd0, 1'b0, 1'b1, 64'hCAFE_F00D_0000_0000, "R6 ack page1");
        wr(2'd2, 6'h08, 64'd0, "R6 sel0");
        access(1'b1, 2'd2, 6'h0C, 64'h11, 64'd0, 1'b0, 1'b1, 64'h11, "R6 ack page0");
        wr(2'd2, 6'h08, 64'd5, "R6 sel5");
        access(1'b1, 2'd2, 6'h0C, 64'hFF, 64'd0, 1'b1, 1'b0, 64'd0, "R6 ack bad page");

        // R13 read-only writes dropped
        wr(2'd2, 6'h00, 64'd0, "R13 sel0");
        wr(2'd2, 6'h04, 64'd0, "R13 feat wr");
        rd(2'd2, 6'h04, 64'h9ABC_DEF0, "R13 feat kept");
        wr(2'd1, 6'h12, 64'd7, "R13 numq wr");
        rd(2'd1, 6'h12, 64'd3, "R7 numq rd");

        // R7 vector, selector, notify
        wr(2'd1, 6'h10, 64'hBEEF, "R7 vec wr");
        rd(2'd1, 6'h10, 64'hBEEF, "R7 vec rd");
        wr(2'd1, 6'h16, 64'd2, "R7 qsel wr");
        rd(2'd1, 6'h16, 64'd2, "R7 qsel rd");
        wr(2'd1, 6'h1E, 64'd1, "R13 notify wr");
        rd(2'd1, 6'h1E, 64'd2, "R7 notify rd");

        // R8 per-queue fields on queue 2
        wr(2'd1, 6'h18, 64'h100, "R8 size wr");
        wr(2'd1, 6'h1A, 64'h7, "R8 vec wr");
        wr(2'd1, 6'h1C, 64'h1, "R8 en wr");
        rd(2'd1, 6'h18, 64'h100, "R8 size rd");
        rd(2'd1, 6'h1A, 64'h7, "R8 vec rd");
        rd(2'd1, 6'h1C, 64'h1, "R8 en rd");
        idle();
        check("R8 size port", 64'(q_size[2*16 +: 16]), 64'h100);
        check("R8 en port", 64'(q_enable), 64'b0100);
        wr(2'd1, 6'h1C, 64'h2, "R8 en wr2");
        rd(2'd1, 6'h1C, 64'h0, "R8 en not exact1");

        // R10 ring bases on queue 2
        wr(2'd2, 6'h20, 64'h1111_2222, "R10 desc lo");
        wr(2'd2, 6'h24, 64'h3333_4444, "R10 desc hi");
        wr(2'd3, 6'h28, 64'hAAAA_BBBB_CCCC_DDDD, "R10 avail 64");
        wr(2'd2, 6'h34, 64'h5, "R10 used hi");
        idle();
        check("R10 desc", q_desc[2*64 +: 64], 64'h3333_4444_1111_2222);
        check("R10 avail", q_avail[2*64 +: 64], 64'hAAAA_BBBB_CCCC_DDDD);
        check("R10 used", q_used[2*64 +: 64], 64'h0000_0005_0000_0000);
        check("R10 other queue", q_desc[0 +: 64], 64'd0);

        // R11 qword reads
        rd(2'd3, 6'h20, 64'd0, "R11 qword ring");
        rd(2'd2, 6'h20, 64'd0, "R11 dword ring lo");

        // R9 selector out of range
        wr(2'd1, 6'h16, 64'd3, "R9 qsel=count");
        wr(2'd1, 6'h18, 64'h40, "R9 size wr");
        rd(2'd1, 6'h18, 64'd0, "R9 size rd");
        wr(2'd1, 6'h16, 64'd9, "R9 qsel big");
        wr(2'd1, 6'h1C, 64'd1, "R9 en wr");
        rd(2'd1, 6'h16, 64'd9, "R9 qsel rd");
        idle();
        check("R9 q3 size", 64'(q_size[3*16 +: 16]), 64'd0);
        check("R9 enables", 64'(q_enable), 64'd0);

        // R12 unlisted size/offset pairs
        access(1'b0, 2'd1, 6'h14, 64'd0, 64'd0, 1'b1, 1'b0, 64'd0, "R12 word at status");
        access(1'b1, 2'd0, 6'h10, 64'hFF, 64'd0, 1'b1, 1'b0, 64'd0, "R12 byte at vec");
        rd(2'd1, 6'h10, 64'hBEEF, "R12 vec kept");
        access(1'b0, 2'd3, 6'h00, 64'd0, 64'd0, 1'b1, 1'b0, 64'd0, "R12 qword at 0");
        access(1'b0, 2'd2, 6'h38, 64'd0, 64'd0, 1'b1, 1'b0, 64'd0, "R12 beyond window");
        idle();
        idle();
        check("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule